// File: doc/BRIEF.md
# Buffered Transfer Byte Counter

This block fixes the length of a buffered serial-bus transfer and decides, byte by byte, whether a received byte is acknowledged. A host loads an 8-bit length register over a plain register port: bits 6:0 carry the number of bytes and bit 7 is a last-byte flag that chooses how the final received byte is answered. A start strobe, raised when the host writes the controller's command register, opens a transfer in the direction given at that moment. A byte-level bus engine then pulses a completion signal once per byte.

A transfer may be 1 to 68 bytes long. An out-of-range length raises the interrupt at once and nothing is transferred. When the programmed number of bytes has been moved, the active flag drops and the interrupt rises. In receive direction the readback reports how many bytes have been stored so far; in transmit direction it returns the programmed length. With the buffered-mode input low, the block ignores start strobes and stays idle.

Top module: `buf_xfer_counter`

## Requirements
- R1: After reset the active flag, the interrupt and the acknowledge output are 0 and the register readback is 8'h00.
- R2: A host write stores all 8 bits, bit 7 as the last-byte flag and bits 6:0 as the length. In transmit direction (rxDir = 0 at the last start) the readback returns the stored value. A host write while a transfer is active is ignored.
- R3: A start strobe with bufMode = 1, no transfer active and a length of 1 to 68 sets the active flag on the next cycle and clears the stored-byte count to 0.
- R4: A start strobe with bufMode = 1 and a length of 0 or 69 to 127 leaves the active flag at 0 and sets the interrupt on the next cycle.
- R5: In receive direction (rxDir = 1 at start) each completion pulse during a transfer adds one to the stored-byte count, which the readback shows in bits 6:0 beside the flag in bit 7.
- R6: In receive direction the acknowledge output is 1 for every byte before the last; for the last byte it is 1 when the flag is 0 and 0 when the flag is 1.
- R7: In transmit direction the acknowledge output stays 0 and the flag has no effect; the transfer still ends after the programmed count.
- R8: The completion pulse for the final byte clears the active flag and sets the interrupt on the next cycle.
- R9: With bufMode = 0 a start strobe changes neither the active flag nor the interrupt.
- R10: An interrupt clear strobe clears the interrupt on the next cycle, unless the interrupt is being set in the same cycle, in which case it stays set.
- R11: While no transfer is active the acknowledge output is 0 and completion pulses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Host write strobe for the length register |
| regWrData | input | 8 | Host write data: flag in bit 7, length in 6:0 |
| regRdData | output | 8 | Readback: flag and length or stored-byte count |
| bufMode | input | 1 | 1 = buffered mode, 0 = byte mode (block idle) |
| startStb | input | 1 | Command-register write strobe that opens a transfer |
| rxDir | input | 1 | Direction at start: 1 = receive, 0 = transmit |
| byteDone | input | 1 | One pulse per byte finished by the bus engine |
| irqClr | input | 1 | Host strobe clearing the interrupt |
| ackOut | output | 1 | Acknowledge decision for the current received byte |
| busy | output | 1 | Transfer active |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the length edges: 0, 1, 68 and 69, where a design with an off-by-one range test would either start a transfer it should refuse or refuse the longest legal one. It checks the acknowledge of the final received byte for both flag values and in transmit direction, where a design that compared against the wrong index would refuse an early byte or answer the last one with the wrong polarity. It also strikes an interrupt clear in the same cycle as the final byte, where a design that gave the clear priority would lose the completion event, and writes the register mid-transfer, where a design that accepted it would move the end point.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  typedef struct packed {
    logic loadCnt;
    logic clrProg;
    logic incProg;
  } bxcStb_t;
endpackage

// File: rtl/bxc_datapath.sv
module bxc_datapath
  import bxc_pkg::*;
#(
  parameter int MAX_LEN = 68,
  parameter int CNT_W   = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  bxcStb_t          stb,
  input  logic [CNT_W:0]   wrData,
  input  logic             dirLat,
  output logic             lastFlag,
  output logic             lenOk,
  output logic             atLast,
  output logic [CNT_W:0]   rdData
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W:0]   cntReg;
  logic [CNT_W-1:0] prog;
  logic [CNT_W-1:0] lenF;

  assign lenF     = cntReg[CNT_W-1:0];
  assign lastFlag = cntReg[CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cntReg <= '0;
    else if (stb.loadCnt) cntReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prog <= '0;
    else if (stb.clrProg) prog <= '0;
    else if (stb.incProg) prog <= prog + ONE;
  end

  assign lenOk  = (lenF != '0) && (lenF <= LIM);
  assign atLast = (prog == lenF - ONE);
  assign rdData = {lastFlag, (dirLat ? prog : lenF)};
endmodule

// File: rtl/bxc_control.sv
module bxc_control
  import bxc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    regWrEn,
  input  logic    bufMode,
  input  logic    startStb,
  input  logic    rxDir,
  input  logic    byteDone,
  input  logic    irqClr,
  input  logic    lenOk,
  input  logic    atLast,
  input  logic    lastFlag,
  output bxcStb_t stb,
  output logic    dirLat,
  output logic    busy,
  output logic    irq,
  output logic    ackOut
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t state, stateNxt;

  logic goStart, badStart, finish, irqSet;

  assign goStart  = (state == ST_IDLE) && bufMode && startStb && lenOk;
  assign badStart = (state == ST_IDLE) && bufMode && startStb && !lenOk;
  assign finish   = (state == ST_RUN) && byteDone && atLast;
  assign irqSet   = badStart || finish;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE: if (goStart) stateNxt = ST_RUN;
      ST_RUN:  if (finish)  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.loadCnt = regWrEn && (state == ST_IDLE);
    stb.clrProg = goStart;
    stb.incProg = (state == ST_RUN) && byteDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      dirLat <= 1'b0;
      irq    <= 1'b0;
    end else begin
      state <= stateNxt;
      if (goStart) dirLat <= rxDir;
      if (irqSet) irq <= 1'b1;
      else if (irqClr) irq <= 1'b0;
    end
  end

  assign busy   = (state == ST_RUN);
  assign ackOut = busy && dirLat && !(atLast && lastFlag);
endmodule

// File: rtl/buf_xfer_counter.sv
module buf_xfer_counter
  import bxc_pkg::*;
#(
  parameter int MAX_LEN = 68,
  parameter int CNT_W   = 7
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic [CNT_W:0] regWrData,
  output logic [CNT_W:0] regRdData,
  input  logic           bufMode,
  input  logic           startStb,
  input  logic           rxDir,
  input  logic           byteDone,
  input  logic           irqClr,
  output logic           ackOut,
  output logic           busy,
  output logic           irq
);
  bxcStb_t stb;
  logic dirLat, lastFlag, lenOk, atLast;

  bxc_control u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .bufMode(bufMode),
    .startStb(startStb), .rxDir(rxDir), .byteDone(byteDone),
    .irqClr(irqClr), .lenOk(lenOk), .atLast(atLast), .lastFlag(lastFlag),
    .stb(stb), .dirLat(dirLat), .busy(busy), .irq(irq), .ackOut(ackOut)
  );

  bxc_datapath #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .dirLat(dirLat), .lastFlag(lastFlag), .lenOk(lenOk),
    .atLast(atLast), .rdData(regRdData)
  );
endmodule

// File: rtl/bxc_checker.sv
module bxc_checker #(
  parameter int CNT_W = 7
) (
  input logic           clk,
  input logic           rstN,
  input logic           regWrEn,
  input logic [CNT_W:0] regRdData,
  input logic           bufMode,
  input logic           startStb,
  input logic           byteDone,
  input logic           irqClr,
  input logic           ackOut,
  input logic           busy,
  input logic           irq
);
  // R11
  idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ackOut);

  // R8
  end_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> irq);

  // R9
  bytemode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !bufMode) |=> !busy);

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqClr && !startStb && !byteDone) |=> !irq);

  // R2
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> $stable(regRdData[CNT_W]));

  // R11
  idle_byte_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteDone && !startStb && !regWrEn) |=> ($stable(regRdData) && !busy));
endmodule

bind buf_xfer_counter bxc_checker #(.CNT_W(CNT_W)) u_bxc_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .bufMode(bufMode), .startStb(startStb), .byteDone(byteDone),
  .irqClr(irqClr), .ackOut(ackOut), .busy(busy), .irq(irq)
);

// File: tb/buf_xfer_counter_bench.sv
module buf_xfer_counter_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, bufMode = 0, startStb = 0, rxDir = 0, byteDone = 0, irqClr = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic ackOut, busy, irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // model state
  logic [7:0] mCnt = '0;
  logic [6:0] mProg = '0;
  bit mBusy = 0, mIrq = 0, mDir = 0;

  always #2.5 clk = ~clk;

  buf_xfer_counter u_buf_xfer_counter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .bufMode(bufMode), .startStb(startStb),
    .rxDir(rxDir), .byteDone(byteDone), .irqClr(irqClr),
    .ackOut(ackOut), .busy(busy), .irq(irq)
  );

  function automatic bit lenValid(logic [6:0] l);
    return (l != 0) && (l <= 7'd68);
  endfunction

  function automatic logic [7:0] expRd();
    return {mCnt[7], (mDir ? mProg : mCnt[6:0])};
  endfunction

  function automatic bit expAck();
    if (!mBusy || !mDir) return 1'b0;
    if (mProg == mCnt[6:0] - 7'd1) return !mCnt[7];
    return 1'b1;
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkState(string req);
    chk(req, busy, mBusy, "busy");
    chk(req, irq, mIrq, "irq");
    chk(req, regRdData, expRd(), "readback");
    chk(req, ackOut, expAck(), "ack");
  endtask

  task automatic writeReg(logic [7:0] v);
    regWrEn = 1; regWrData = v;
    tick();
    regWrEn = 0;
    if (!mBusy) mCnt = v;
  endtask

  task automatic startXfer(bit dir);
    rxDir = dir; startStb = 1;
    tick();
    startStb = 0;
    if (bufMode && !mBusy) begin
      if (lenValid(mCnt[6:0])) begin
        mBusy = 1; mDir = dir; mProg = 0;
      end else mIrq = 1;
    end
  endtask

  task automatic byteStep(bit withClr);
    byteDone = 1; irqClr = withClr;
    tick();
    byteDone = 0; irqClr = 0;
    if (withClr) mIrq = 0;
    if (mBusy) begin
      mProg = mProg + 7'd1;
      if (mProg == mCnt[6:0]) begin mBusy = 0; mIrq = 1; end
    end
  endtask

  task automatic clearIrq();
    irqClr = 1;
    tick();
    irqClr = 0;
    mIrq = 0;
    chk("R10", irq, 0, "irq after clear");
  endtask

  task automatic runXfer(logic [7:0] v, bit dir, bit lastClr);
    writeReg(v);
    chk("R2", regRdData, expRd(), "readback after write");
    startXfer(dir);
    if (!lenValid(v[6:0])) chkState("R4");
    else chkState("R3");
    while (mBusy) begin
      if (mDir) chk("R6", ackOut, expAck(), "ack before byte");
      else chk("R7", ackOut, 0, "tx ack");
      byteStep(lastClr && (mProg == mCnt[6:0] - 7'd1));
      chkState(mBusy ? "R5" : "R8");
    end
    clearIrq();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    rstN = 1;
    tick();
    chk("R1", busy, 0, "busy"); chk("R1", irq, 0, "irq");
    chk("R1", ackOut, 0, "ack"); chk("R1", regRdData, 0, "readback");

    // byte mode: start ignored
    writeReg(8'h05);
    startXfer(1'b1);
    chkState("R9");
    chk("R9", busy, 0, "busy byte mode"); chk("R9", irq, 0, "irq byte mode");

    bufMode = 1;
    // idle completion pulse ignored
    byteStep(1'b0);
    chkState("R11");

    // directed length edges
    runXfer(8'h00, 1'b1, 1'b0);
    runXfer(8'h45, 1'b0, 1'b0);
    runXfer(8'h7F, 1'b1, 1'b0);
    runXfer(8'h01, 1'b1, 1'b0);
    runXfer(8'h81, 1'b1, 1'b0);
    runXfer(8'hC4, 1'b1, 1'b0);
    runXfer(8'h44, 1'b1, 1'b0);
    runXfer(8'hC4, 1'b0, 1'b0);
    // clear in same cycle as final byte: set wins
    runXfer(8'h03, 1'b1, 1'b1);

    // write while busy ignored
    writeReg(8'h84);
    startXfer(1'b0);
    writeReg(8'h02);
    chk("R2", regRdData, 8'h84, "readback after busy write");
    while (mBusy) begin byteStep(1'b0); chkState("R2"); end
    clearIrq();

    // random transfers
    for (int i = 0; i < 60; i++) begin
      logic [7:0] v;
      v = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) v[6:0] = 7'($urandom_range(1, 68));
      runXfer(v, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule